// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block lets a host reach a small bank of 8-bit configuration registers through three pins: an active-low select, a serial clock and one bidirectional data line. The data line appears at the block's edge as an input, an output and an output-enable, so the pad ring decides how to merge them. All pins are oversampled by a system clock at least eight times faster than the serial clock. Only the rising edges of the synchronized serial clock move data in, so the serial clock may run at any duty cycle and as slowly as the host wishes.

Each transfer is a 24-bit word sent most significant bit first. While select stays low, words may follow one another without a gap, and each completed word takes effect in turn. A word cut short by select rising is dropped. A read word returns the addressed register on the data line during its last eight bit periods. A parallel read port lets on-chip logic observe every register at any time.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register i holds 0x80 + i (with the default base 0x80), and the data output-enable is low.
- R2: A word is 24 bits, MSB first, sampled on synchronized rising clock edges: bit 23 is the read flag (1 = read), bits 22:8 the address, bits 7:0 the data. A write word updates the addressed register at its 24th rising edge after select falls.
- R3: Several whole words sent in one select-low window are each applied, in the order sent.
- R4: If select rises after a number of rising edges that is not a multiple of 24, the unfinished word changes no register.
- R5: While select is high the bit counter and shift register stay cleared and serial clock edges have no effect; a new window always starts at bit 23.
- R6: For a read word, the addressed register's 8 bits are driven MSB first during bit periods 17 to 24, changing on falling edges; output-enable is high only during those periods.
- R7: A read word never modifies any register.
- R8: A write to an address at or above the register count is ignored; a read from such an address returns zero.
- R9: Behaviour is the same for very slow and for strongly asymmetric serial clocks, provided each clock phase lasts at least five system cycles.
- R10: The parallel read port returns the current content of the register it selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| sel_n_i | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial read data toward the pad |
| sdio_oe | output | 1 | High while the block drives the data pad |
| par_idx_i | input | 3 | Register index for the parallel read port |
| par_data_o | output | 8 | Content of the selected register |

## Verification
Checked on every cycle by assertions: the bit counter never leaves 0..23, output-enable rises only inside the read window of a word, select high clears the counter and drops output-enable, a read word never raises the write strobe, and no register changes without a write strobe. Only the bench's scenarios can show that register contents after back-to-back words, truncated words, out-of-range addresses and slow or lopsided clocks match the expected model, and that the serial read data carries the right bits in the right order.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int HDR_W  = 1 + ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W);

    // Decoded serial word, bit 23 first on the wire
    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Synchronized pin events handed to the frame engine
    typedef struct packed {
        logic rise;
        logic fall;
        logic idle;
        logic din;
    } pin_evt_t;

    function automatic logic [DATA_W-1:0] reset_value(input logic [DATA_W-1:0] base,
                                                      input int unsigned       idx);
        logic [31:0] wide;
        wide = idx;
        return base + wide[DATA_W-1:0];
    endfunction

    function automatic logic addr_valid(input logic [ADDR_W-1:0] a, input int unsigned n);
        return 32'(a) < n;
    endfunction

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync
    import cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     sel_n_i,
    input  logic     sdio_i,
    output pin_evt_t evt
);

    localparam int         NPIN    = 3;
    localparam logic [2:0] RST_PAT = 3'b010; // select idles high

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] synced;
    logic            sclk_q;

    assign raw = {sdio_i, sel_n_i, sclk_i};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_pin
            logic [STAGES-1:0] ff;
            always_ff @(posedge clk) begin
                if (rst) ff <= {STAGES{RST_PAT[g]}};
                else     ff <= {ff[STAGES-2:0], raw[g]};
            end
            assign synced[g] = ff[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= synced[0];
    end

    assign evt.rise = synced[0] & ~sclk_q;
    assign evt.fall = ~synced[0] & sclk_q;
    assign evt.idle = synced[1];
    assign evt.din  = synced[2];

endmodule

// File: rtl/cfg_frame_engine.sv
module cfg_frame_engine
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              oe
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HDR_BIT  = CNT_W'(HDR_W - 1);

    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              rd_act;
    logic [DATA_W-1:0] out_sh;
    logic              sdo_q;
    logic              oe_q;
    logic [WORD_W-1:0] word_bits;
    logic [HDR_W-1:0]  hdr_bits;
    frame_t            word_now;

    assign word_bits = {shreg, evt.din};
    assign hdr_bits  = word_bits[HDR_W-1:0];
    assign word_now  = frame_t'(word_bits);

    assign rd_addr = hdr_bits[ADDR_W-1:0];
    assign wr_en   = evt.rise && !evt.idle && (cnt == LAST_BIT) && !word_now.rd;
    assign wr_addr = word_now.addr;
    assign wr_data = word_now.data;
    assign sdo     = sdo_q;
    assign oe      = oe_q;

    always_ff @(posedge clk) begin
        if (rst || evt.idle) begin
            shreg  <= '0;
            cnt    <= '0;
            rd_act <= 1'b0;
            out_sh <= '0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (evt.rise) begin
            shreg <= word_bits[WORD_W-2:0];
            if (cnt == LAST_BIT) begin
                cnt    <= '0;
                rd_act <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == HDR_BIT) begin
                    rd_act <= hdr_bits[HDR_W-1];
                    out_sh <= rd_data;
                end
            end
        end else if (evt.fall && rd_act) begin
            sdo_q  <= out_sh[DATA_W-1];
            out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            oe_q   <= 1'b1;
        end
    end

    logic idle_w;
    assign idle_w = evt.idle;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_BIT)
        else $error("bit counter out of range");

    p_oe_window_r6: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (cnt >= CNT_W'(HDR_W)))
        else $error("output enable outside read window");

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(idle_w) |-> (cnt == '0 && !oe_q))
        else $error("state not cleared while select high");

    p_read_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !rd_act)
        else $error("write strobe during read word");

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [DATA_W-1:0] RST_BASE = 8'h80,
    localparam int               IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ser_addr,
    output logic [DATA_W-1:0] ser_data,
    input  logic [IDX_W-1:0]  par_idx,
    output logic [DATA_W-1:0] par_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reset_value(RST_BASE, g);
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= wr_data;
            end
            assign regs[g] = q;
        end
    endgenerate

    always_comb begin
        ser_data = '0;
        if (addr_valid(ser_addr, NUM_REGS))
            ser_data = regs[ser_addr[IDX_W-1:0]];
    end

    always_comb begin
        par_data = '0;
        if (32'(par_idx) < NUM_REGS)
            par_data = regs[par_idx];
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(regs))
        else $error("register changed without a write strobe");

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_pkg::*;
#(
    parameter int                NUM_REGS    = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] RST_BASE    = 8'h80,
    localparam int               IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    input  logic [IDX_W-1:0]  par_idx_i,
    output logic [DATA_W-1:0] par_data_o
);

    pin_evt_t          evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    cfg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .sel_n_i (sel_n_i),
        .sdio_i  (sdio_i),
        .evt     (evt)
    );

    cfg_frame_engine u_frame (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (sdio_o),
        .oe      (sdio_oe)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ser_addr (rd_addr),
        .ser_data (rd_data),
        .par_idx  (par_idx_i),
        .par_data (par_data_o)
    );

endmodule

// File: tb/cfg_serial_slave_bench.sv
`timescale 1ns/1ps
module cfg_serial_slave_bench;

    localparam int NREG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic       sdio = 1'b0;
    logic       sdio_o;
    logic       sdio_oe;
    logic [2:0] par_idx = 3'd0;
    logic [7:0] par_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [7:0] expv [NREG];

    always #4 clk = ~clk;

    cfg_serial_slave #(.NUM_REGS(NREG)) u_cfg_serial_slave (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .sel_n_i    (sel_n),
        .sdio_i     (sdio),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe),
        .par_idx_i  (par_idx),
        .par_data_o (par_data)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expd);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expd);
        end
    endtask

    function automatic logic [23:0] mk(input bit rd, input logic [14:0] a, input logic [7:0] d);
        return {rd, a, d};
    endfunction

    function automatic logic [7:0] model_read(input logic [14:0] a);
        return (a < NREG) ? expv[a[2:0]] : 8'h00;
    endfunction

    function automatic void model_apply(input logic [23:0] w);
        if (!w[23] && w[22:8] < NREG) expv[w[10:8]] = w[7:0];
    endfunction

    // Shift nbits of w, MSB first; collects read data in bit periods 17..24
    task automatic shift_word(input logic [23:0] w, input int nbits, input int lo, input int hi,
                              output logic [7:0] got, output bit oe_bad);
        got = 8'h00;
        oe_bad = 0;
        for (int i = 0; i < nbits; i++) begin
            sdio = w[23-i];
            wait_clk(lo);
            if (w[23] && i >= 16) begin
                got = {got[6:0], sdio_o};
                if (!sdio_oe) oe_bad = 1;
            end else if (sdio_oe) begin
                oe_bad = 1;
            end
            sclk = 1'b1;
            wait_clk(hi);
            sclk = 1'b0;
        end
    endtask

    task automatic open_win(input int lo);
        sel_n = 1'b0;
        wait_clk(lo);
    endtask

    task automatic close_win(input int lo);
        wait_clk(lo);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    // Complete word: updates the model, checks read data and enable window
    task automatic full_word(input logic [23:0] w, input int lo, input int hi, input string req);
        logic [7:0] got;
        bit oe_bad;
        logic [7:0] want;
        want = model_read(w[22:8]);
        shift_word(w, 24, lo, hi, got, oe_bad);
        if (w[23]) check(got == want, {req, "/R6 read data"}, int'(got), int'(want));
        check(!oe_bad, {req, "/R6 enable window"}, int'(oe_bad), 0);
        model_apply(w);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NREG; i++) begin
            par_idx = 3'(i);
            wait_clk(2);
            check(par_data == expv[i], {req, "/R10 register"}, int'(par_data), int'(expv[i]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        bit oe_bad;
        void'($urandom(32'h5eed));
        for (int i = 0; i < NREG; i++) expv[i] = 8'h80 + 8'(i);
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state
        check(sdio_oe == 1'b0, "R1 oe after reset", int'(sdio_oe), 0);
        check_all("R1");

        // R2: single write
        open_win(6);
        full_word(mk(0, 15'd3, 8'h3C), 6, 6, "R2");
        close_win(6);
        check_all("R2");

        // R3: back-to-back words, same register twice
        open_win(6);
        full_word(mk(0, 15'd0, 8'h11), 6, 7, "R3");
        full_word(mk(0, 15'd5, 8'hA5), 6, 7, "R3");
        full_word(mk(0, 15'd0, 8'h22), 6, 7, "R3");
        close_win(6);
        check_all("R3");

        // R4: trailing partial words dropped (short and one bit short)
        open_win(6);
        full_word(mk(0, 15'd6, 8'h66), 6, 6, "R4");
        shift_word(mk(0, 15'd1, 8'hFF), 10, 6, 6, got, oe_bad);
        close_win(6);
        check_all("R4 short tail");
        open_win(6);
        shift_word(mk(0, 15'd2, 8'h00), 23, 6, 6, got, oe_bad);
        close_win(6);
        check_all("R4 23-bit tail");

        // R5: clocks with select high have no effect; next window starts fresh
        sdio = 1'b1;
        for (int i = 0; i < 30; i++) begin
            sclk = 1'b1; wait_clk(5); sclk = 1'b0; wait_clk(5);
        end
        check(sdio_oe == 1'b0, "R5 oe while idle", int'(sdio_oe), 0);
        open_win(6);
        full_word(mk(0, 15'd4, 8'h4D), 6, 6, "R5");
        close_win(6);
        check_all("R5");

        // R6/R7: read back, no write side effect
        open_win(6);
        full_word(mk(1, 15'd3, 8'hEE), 6, 6, "R6");
        full_word(mk(1, 15'd5, 8'h00), 6, 6, "R7");
        close_win(6);
        check_all("R7");

        // R8: out-of-range addresses
        open_win(6);
        full_word(mk(0, 15'h4001, 8'h99), 6, 6, "R8 write");
        full_word(mk(0, 15'd8, 8'h98), 6, 6, "R8 write");
        full_word(mk(1, 15'h0100, 8'h00), 6, 6, "R8 read zero");
        close_win(6);
        check_all("R8");

        // R9: slow and asymmetric clocks
        open_win(20);
        full_word(mk(0, 15'd7, 8'h5B), 400, 400, "R9 slow");
        close_win(20);
        open_win(6);
        full_word(mk(1, 15'd7, 8'h00), 40, 5, "R9 short high");
        full_word(mk(0, 15'd1, 8'hC3), 5, 60, "R9 short low");
        full_word(mk(1, 15'd1, 8'h00), 5, 60, "R9 short low");
        close_win(6);
        check_all("R9");

        // Random windows: mixed reads, writes, addresses, timing, partial tails
        for (int it = 0; it < 40; it++) begin
            int nw;
            int lo;
            int hi;
            lo = 5 + int'($urandom_range(9));
            hi = 5 + int'($urandom_range(9));
            nw = 1 + int'($urandom_range(2));
            open_win(lo);
            for (int k = 0; k < nw; k++) begin
                logic [14:0] a;
                a = ($urandom_range(3) == 0) ? 15'($urandom) : 15'($urandom_range(NREG + 2));
                full_word(mk(1'($urandom), a, 8'($urandom)), lo, hi, "R3 random");
            end
            if ($urandom_range(2) == 0)
                shift_word(mk(0, 15'($urandom_range(NREG - 1)), 8'($urandom)),
                           1 + int'($urandom_range(22)), lo, hi, got, oe_bad);
            close_win(lo);
            check(sdio_oe == 1'b0, "R5 oe after window", int'(sdio_oe), 0);
            check_all("R4 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule